// File: doc/BRIEF.md
# Ping-Pong Receive Buffer for a USB OUT Endpoint

This block stores the payload of USB OUT packets on their way from the serial interface engine to a CPU. Received bytes go into one of two banks of 64 bytes each. While the CPU drains one bank, the engine can fill the other. A packet is kept only when it ends well. When it is kept, the block returns ACK to the engine, records the packet length for the CPU and raises a data-available interrupt, all in the same clock cycle. A packet that ends badly, runs past one bank, or arrives while both banks are occupied is refused with NAK and leaves no trace.

The CPU handles a packet in three steps:
1. It reads the length from a count register.
2. It reads exactly that many bytes, one after another, from a single byte-wide data register. An internal read pointer advances on each data read.
3. It gives the bank back by pulsing the interrupt clear. If the other bank already holds a kept packet, the interrupt rises again at once and the pointer starts over at byte 0.

Bank memory has no reset. Its contents are undefined after power-on and are never cleared by reset.

Top module: `usb_out_pingpong_buf`

## Requirements
- R1: After reset, `dav_irq`, `sie_hs_vld` and `cpu_rdata` are 0.
- R2: A packet of 0 to 64 bytes that ends with `sie_pkt_good`=1, and that starts while a bank is free, is answered in the cycle after its end strobe. The answer is `sie_hs_vld`=1 with `sie_ack`=1, and `dav_irq` is high from that same cycle.
- R3: Reads at address 0x11 return the kept bytes in arrival order, one byte per read. The pointer restarts at byte 0 whenever a bank is handed to the CPU.
- R4: A read at address 0x12 returns the length of the packet held by the CPU in bits [6:0], with bit 7 = 0.
- R5: A packet that ends with `sie_pkt_good`=0 is answered with `sie_hs_vld`=1 and `sie_ack`=0, and neither the interrupt nor the count changes.
- R6: A packet of more than 64 bytes is answered with NAK and is not kept.
- R7: A packet that starts while both banks hold kept packets is answered with NAK. Its bytes are discarded, and the stored packets read back unchanged.
- R8: A zero-length packet is kept with a count of 0 and raises `dav_irq`.
- R9: A `dav_clr` pulse while `dav_irq` is high releases the CPU bank. If the other bank holds a kept packet, `dav_irq` is still high in the next cycle and that packet is then read. Packets are delivered in arrival order.
- R10: While `dav_irq` is low, `dav_clr` has no effect, and data and count reads return 0.
- R11: A `dav_clr` that falls in the same cycle as the end strobe of a good packet both releases the old bank and keeps the new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sie_pkt_start | input | 1 | Start of an OUT packet |
| sie_byte_vld | input | 1 | `sie_byte` carries a payload byte |
| sie_byte | input | 8 | Payload byte |
| sie_pkt_end | input | 1 | End of packet |
| sie_pkt_good | input | 1 | Packet was received without error (sampled with `sie_pkt_end`) |
| sie_hs_vld | output | 1 | Handshake decision is valid |
| sie_ack | output | 1 | 1 = ACK, 0 = NAK |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 5 | Register address |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_rd` |
| dav_clr | input | 1 | Interrupt clear and bank release |
| dav_irq | output | 1 | Data-available interrupt |

## Verification
The end of a good packet and the CPU's bank release can fall in the same cycle. They touch different banks, but both update the same full flags and bank selectors. The bench provokes this by holding `dav_clr` high during the end strobe of a new packet while the CPU still owns an earlier one. It then judges the outcome at the ports:
- ACK is returned for the new packet.
- The interrupt stays high.
- The count register shows the new length.
- The data register returns the new bytes from byte 0.

// File: rtl/usbo_pkg.sv
package usbo_pkg;
  localparam int BANK_BYTES_DEF = 64;
  localparam int ADDR_W_DEF     = 5;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_RECV = 2'd1,
    RX_DROP = 2'd2
  } rx_state_e;
endpackage

// File: rtl/usbo_rst_sync.sv
module usbo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/usbo_rx_ctrl.sv
module usbo_rx_ctrl
  import usbo_pkg::*;
#(
  parameter int BANK_BYTES = BANK_BYTES_DEF,
  localparam int PTR_W = $clog2(BANK_BYTES),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             pkt_start,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  input  logic             pkt_end,
  input  logic             pkt_good,
  input  logic             bank_free,
  output logic             mem_we,
  output logic [PTR_W-1:0] mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             commit,
  output logic [CNT_W-1:0] commit_len,
  output logic             hs_vld,
  output logic             hs_ack
);
  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] wptr_q, wptr_d;
  logic             ovf_q, ovf_d;
  logic             hs_vld_d, hs_ack_d;
  logic             bank_full;

  assign bank_full = (wptr_q == CNT_W'(BANK_BYTES));

  always_comb begin
    state_d   = state_q;
    wptr_d    = wptr_q;
    ovf_d     = ovf_q;
    hs_vld_d  = 1'b0;
    hs_ack_d  = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = wptr_q[PTR_W-1:0];
    mem_wdata = byte_in;
    if (pkt_start) begin
      state_d = bank_free ? RX_RECV : RX_DROP;
      wptr_d  = '0;
      ovf_d   = 1'b0;
    end else if (byte_vld && state_q == RX_RECV) begin
      if (bank_full) begin
        ovf_d = 1'b1;
      end else begin
        mem_we = 1'b1;
        wptr_d = wptr_q + CNT_W'(1);
      end
    end else if (pkt_end && state_q != RX_IDLE) begin
      hs_vld_d = 1'b1;
      hs_ack_d = (state_q == RX_RECV) && pkt_good && !ovf_q;
      state_d  = RX_IDLE;
    end
  end

  assign commit     = hs_ack_d;
  assign commit_len = wptr_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= RX_IDLE;
      wptr_q  <= '0;
      ovf_q   <= 1'b0;
      hs_vld  <= 1'b0;
      hs_ack  <= 1'b0;
    end else begin
      state_q <= state_d;
      wptr_q  <= wptr_d;
      ovf_q   <= ovf_d;
      hs_vld  <= hs_vld_d;
      hs_ack  <= hs_ack_d;
    end
  end
endmodule

// File: rtl/usbo_bank_store.sv
module usbo_bank_store #(
  parameter int BANK_BYTES = 64,
  parameter int NUM_BANKS  = 2,
  localparam int PTR_W = $clog2(BANK_BYTES),
  localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SEL_W-1:0] wbank,
  input  logic [PTR_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [SEL_W-1:0] rbank,
  input  logic [PTR_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] bank_rd [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [7:0] mem [BANK_BYTES];
    logic       bank_we;

    assign bank_we = we && (wbank == SEL_W'(g));

    // Storage carries no reset: contents survive any reset.
    always_ff @(posedge clk) begin
      if (bank_we) mem[waddr] <= wdata;
    end

    assign bank_rd[g] = mem[raddr];
  end

  assign rdata = bank_rd[rbank];
endmodule

// File: rtl/usbo_cpu_port.sv
module usbo_cpu_port #(
  parameter int          BANK_BYTES = 64,
  parameter int          ADDR_W     = 5,
  parameter logic [4:0]  DATA_ADDR  = 5'h11,
  parameter logic [4:0]  COUNT_ADDR = 5'h12,
  localparam int PTR_W = $clog2(BANK_BYTES),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              commit,
  input  logic [CNT_W-1:0]  commit_len,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              clr,
  input  logic [7:0]        store_rdata,
  output logic              fill_sel,
  output logic              own_sel,
  output logic              bank_free,
  output logic [PTR_W-1:0]  rptr,
  output logic [1:0]        full,
  output logic              irq,
  output logic [7:0]        rdata
);
  logic [1:0]       full_q, full_d;
  logic [CNT_W-1:0] cnt_q [2];
  logic [CNT_W-1:0] cnt_d [2];
  logic             fill_q, fill_d, own_q, own_d;
  logic [PTR_W-1:0] rptr_q, rptr_d;
  logic [7:0]       rdata_q, rdata_d;
  logic             irq_w, release_w;

  assign irq_w     = full_q[own_q];
  assign release_w = clr && irq_w;

  always_comb begin
    full_d  = full_q;
    cnt_d   = cnt_q;
    fill_d  = fill_q;
    own_d   = own_q;
    rptr_d  = rptr_q;
    rdata_d = rdata_q;
    if (commit) begin
      full_d[fill_q] = 1'b1;
      cnt_d[fill_q]  = commit_len;
      fill_d         = ~fill_q;
    end
    if (rd) begin
      if (addr == ADDR_W'(DATA_ADDR)) begin
        rdata_d = irq_w ? store_rdata : 8'h00;
        if (irq_w) rptr_d = rptr_q + PTR_W'(1);
      end else if (addr == ADDR_W'(COUNT_ADDR)) begin
        rdata_d = irq_w ? 8'(cnt_q[own_q]) : 8'h00;
      end else begin
        rdata_d = 8'h00;
      end
    end
    if (release_w) begin
      full_d[own_q] = 1'b0;
      own_d         = ~own_q;
      rptr_d        = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      full_q   <= 2'b00;
      cnt_q[0] <= '0;
      cnt_q[1] <= '0;
      fill_q   <= 1'b0;
      own_q    <= 1'b0;
      rptr_q   <= '0;
      rdata_q  <= 8'h00;
    end else begin
      full_q   <= full_d;
      cnt_q[0] <= cnt_d[0];
      cnt_q[1] <= cnt_d[1];
      fill_q   <= fill_d;
      own_q    <= own_d;
      rptr_q   <= rptr_d;
      rdata_q  <= rdata_d;
    end
  end

  assign fill_sel  = fill_q;
  assign own_sel   = own_q;
  assign bank_free = !full_q[fill_q];
  assign rptr      = rptr_q;
  assign full      = full_q;
  assign irq       = irq_w;
  assign rdata     = rdata_q;
endmodule

// File: rtl/usb_out_pingpong_buf.sv
module usb_out_pingpong_buf
  import usbo_pkg::*;
#(
  parameter int         BANK_BYTES = BANK_BYTES_DEF,
  parameter int         ADDR_W     = ADDR_W_DEF,
  parameter logic [4:0] DATA_ADDR  = 5'h11,
  parameter logic [4:0] COUNT_ADDR = 5'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sie_pkt_start,
  input  logic              sie_byte_vld,
  input  logic [7:0]        sie_byte,
  input  logic              sie_pkt_end,
  input  logic              sie_pkt_good,
  output logic              sie_hs_vld,
  output logic              sie_ack,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [7:0]        cpu_rdata,
  input  logic              dav_clr,
  output logic              dav_irq
);
  localparam int PTR_W = $clog2(BANK_BYTES);
  localparam int CNT_W = PTR_W + 1;

  logic             rst_sn;
  logic             mem_we, commit, bank_free, fill_sel, own_sel;
  logic [PTR_W-1:0] mem_addr, rptr_w;
  logic [7:0]       mem_wdata, store_rdata;
  logic [CNT_W-1:0] commit_len;
  logic [1:0]       full_w;

  usbo_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_sn (rst_sn)
  );

  usbo_rx_ctrl #(.BANK_BYTES(BANK_BYTES)) u_rx (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .pkt_start  (sie_pkt_start),
    .byte_vld   (sie_byte_vld),
    .byte_in    (sie_byte),
    .pkt_end    (sie_pkt_end),
    .pkt_good   (sie_pkt_good),
    .bank_free  (bank_free),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .commit     (commit),
    .commit_len (commit_len),
    .hs_vld     (sie_hs_vld),
    .hs_ack     (sie_ack)
  );

  usbo_bank_store #(.BANK_BYTES(BANK_BYTES), .NUM_BANKS(2)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .wbank (fill_sel),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .rbank (own_sel),
    .raddr (rptr_w),
    .rdata (store_rdata)
  );

  usbo_cpu_port #(
    .BANK_BYTES (BANK_BYTES),
    .ADDR_W     (ADDR_W),
    .DATA_ADDR  (DATA_ADDR),
    .COUNT_ADDR (COUNT_ADDR)
  ) u_cpu (
    .clk         (clk),
    .rst_sn      (rst_sn),
    .commit      (commit),
    .commit_len  (commit_len),
    .rd          (cpu_rd),
    .addr        (cpu_addr),
    .clr         (dav_clr),
    .store_rdata (store_rdata),
    .fill_sel    (fill_sel),
    .own_sel     (own_sel),
    .bank_free   (bank_free),
    .rptr        (rptr_w),
    .full        (full_w),
    .irq         (dav_irq),
    .rdata       (cpu_rdata)
  );
endmodule

// File: rtl/usbo_checker.sv
module usbo_checker #(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             sie_pkt_end,
  input logic             sie_hs_vld,
  input logic             sie_ack,
  input logic             dav_irq,
  input logic             dav_clr,
  input logic [1:0]       full_w,
  input logic [PTR_W-1:0] rptr_w
);
  // R2: a handshake only follows an end strobe
  p_hs_after_end_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    sie_hs_vld |-> $past(sie_pkt_end));

  // R2: ACK and interrupt appear together
  p_ack_raises_irq_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (sie_hs_vld && sie_ack) |-> dav_irq);

  // R5: a NAK never raises the interrupt
  p_nak_keeps_irq_low_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (sie_hs_vld && !sie_ack && !$past(dav_irq)) |-> !dav_irq);

  // R7: no ACK while both banks were occupied
  p_no_ack_when_full_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (sie_hs_vld && sie_ack) |-> ($past(full_w) != 2'b11));

  // R3: the pointer restarts after a hand-over
  p_rptr_restart_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (dav_clr && dav_irq) |=> (rptr_w == '0));
endmodule

bind usb_out_pingpong_buf usbo_checker #(.PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst_sn      (rst_sn),
  .sie_pkt_end (sie_pkt_end),
  .sie_hs_vld  (sie_hs_vld),
  .sie_ack     (sie_ack),
  .dav_irq     (dav_irq),
  .dav_clr     (dav_clr),
  .full_w      (full_w),
  .rptr_w      (rptr_w)
);

// File: tb/usb_out_pingpong_buf_tb_top.sv
module usb_out_pingpong_buf_tb_top;
  localparam logic [4:0] A_DATA  = 5'h11;
  localparam logic [4:0] A_COUNT = 5'h12;
  // vector: {len[7:0], seed[7:0], good, exp_ack}
  localparam int NVEC = 7;
  localparam logic [17:0] VEC [NVEC] = '{
    {8'd5,  8'd1, 1'b1, 1'b1},
    {8'd64, 8'd2, 1'b1, 1'b1},
    {8'd1,  8'd3, 1'b1, 1'b1},
    {8'd65, 8'd4, 1'b1, 1'b0},
    {8'd10, 8'd5, 1'b0, 1'b0},
    {8'd0,  8'd6, 1'b1, 1'b1},
    {8'd33, 8'd7, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sie_pkt_start = 1'b0, sie_byte_vld = 1'b0, sie_pkt_end = 1'b0, sie_pkt_good = 1'b0;
  logic [7:0] sie_byte = 8'h00;
  logic sie_hs_vld, sie_ack, dav_irq;
  logic cpu_rd = 1'b0, dav_clr = 1'b0;
  logic [4:0] cpu_addr = 5'h00;
  logic [7:0] cpu_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic hs_seen, ack_seen;

  always #2 clk = ~clk;

  usb_out_pingpong_buf dut_i (
    .clk(clk), .rst_n(rst_n),
    .sie_pkt_start(sie_pkt_start), .sie_byte_vld(sie_byte_vld), .sie_byte(sie_byte),
    .sie_pkt_end(sie_pkt_end), .sie_pkt_good(sie_pkt_good),
    .sie_hs_vld(sie_hs_vld), .sie_ack(sie_ack),
    .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
    .dav_clr(dav_clr), .dav_irq(dav_irq)
  );

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 29 + k * 7 + 3) & 255);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Sends a packet; hs_seen/ack_seen are sampled in the cycle after the end strobe.
  task automatic send_pkt(input int len, input int seed, input bit good, input bit clr_at_end);
    @(negedge clk); sie_pkt_start = 1'b1;
    @(negedge clk); sie_pkt_start = 1'b0;
    for (int k = 0; k < len; k++) begin
      sie_byte_vld = 1'b1; sie_byte = pat(seed, k);
      @(negedge clk);
    end
    sie_byte_vld = 1'b0;
    sie_pkt_end = 1'b1; sie_pkt_good = good; dav_clr = clr_at_end;
    @(negedge clk);
    sie_pkt_end = 1'b0; sie_pkt_good = 1'b0; dav_clr = 1'b0;
    hs_seen = sie_hs_vld; ack_seen = sie_ack;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk); cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk); cpu_rd = 1'b0;
    v = cpu_rdata;
  endtask

  task automatic pulse_clr();
    @(negedge clk); dav_clr = 1'b1;
    @(negedge clk); dav_clr = 1'b0;
  endtask

  // Reads count and bytes of the packet held by the CPU and compares.
  task automatic drain(input string req, input int len, input int seed);
    logic [7:0] v;
    int errs;
    rd_reg(A_COUNT, v);
    chk(req, "count", int'(v), len);
    errs = 0;
    for (int k = 0; k < len; k++) begin
      rd_reg(A_DATA, v);
      if (v != pat(seed, k)) begin
        if (errs == 0) chk(req, $sformatf("byte %0d", k), int'(v), int'(pat(seed, k)));
        errs++;
      end
    end
    if (errs == 0) chk(req, "all bytes", 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "irq", int'(dav_irq), 0);
    chk("R1", "hs_vld", int'(sie_hs_vld), 0);
    chk("R1", "rdata", int'(cpu_rdata), 0);

    // Table walk: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NVEC; i++) begin
      int len, seed;
      bit good, ack;
      len = int'(VEC[i][17:10]); seed = int'(VEC[i][9:2]);
      good = VEC[i][1]; ack = VEC[i][0];
      send_pkt(len, seed, good, 1'b0);
      chk(ack ? "R2" : (good ? "R6" : "R5"), "hs_vld", int'(hs_seen), 1);
      chk(ack ? "R2" : (good ? "R6" : "R5"), "ack", int'(ack_seen), int'(ack));
      chk(len == 0 ? "R8" : "R2", "irq", int'(dav_irq), int'(ack));
      if (ack) begin
        drain(len == 0 ? "R8" : "R3", len, seed);
        pulse_clr();
        chk("R9", "irq after release", int'(dav_irq), 0);
      end else begin
        rd_reg(A_COUNT, v);
        chk("R5", "count unchanged", int'(v), 0);
      end
    end

    // R10: clear and reads with no packet held
    pulse_clr();
    rd_reg(A_DATA, v);
    chk("R10", "data read idle", int'(v), 0);
    rd_reg(A_COUNT, v);
    chk("R10", "count read idle", int'(v), 0);

    // R7 and R9: fill both banks, then a third packet
    send_pkt(3, 10, 1'b1, 1'b0);
    chk("R9", "ack A", int'(ack_seen), 1);
    send_pkt(4, 11, 1'b1, 1'b0);
    chk("R9", "ack B", int'(ack_seen), 1);
    send_pkt(2, 12, 1'b1, 1'b0);
    chk("R7", "hs_vld C", int'(hs_seen), 1);
    chk("R7", "nak C", int'(ack_seen), 0);
    rd_reg(A_DATA, v);
    chk("R3", "first byte A", int'(v), int'(pat(10, 0)));
    pulse_clr();
    chk("R9", "irq re-raised", int'(dav_irq), 1);
    drain("R7", 4, 11);
    pulse_clr();
    chk("R9", "irq low after both", int'(dav_irq), 0);

    // R11: end of a good packet coincides with release
    send_pkt(2, 20, 1'b1, 1'b0);
    chk("R11", "ack D", int'(ack_seen), 1);
    send_pkt(6, 21, 1'b1, 1'b1);
    chk("R11", "ack E", int'(ack_seen), 1);
    chk("R11", "irq held", int'(dav_irq), 1);
    drain("R11", 6, 21);
    pulse_clr();
    chk("R11", "irq low after E", int'(dav_irq), 0);

    // R4: count register bit 7 stays 0 on a full bank
    send_pkt(64, 30, 1'b1, 1'b0);
    rd_reg(A_COUNT, v);
    chk("R4", "count full bank", int'(v), 64);
    pulse_clr();

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule